// File: doc/BRIEF.md
# Deferred Condition-Code Flag Evaluator

This block rebuilds a processor's condition-code flags after an arithmetic step has finished. That step does not compute the flags itself. It stores three things: a 4-bit class code that names what it did, the value it produced, and one of its operands. Later, when software or the pipeline needs the flags, this block turns those three values into a 5-bit flag word. It reports negative, zero, overflow and carry. It can also pass a stored flag word through unchanged.

The block is purely combinational. Subtraction is handled without the first operand. The minuend is recovered as the sum of the stored result and the stored operand, and carry and overflow follow from that sum. The same idea, with the ±1 adjustment, covers the extended add and subtract that include the extend bit.

A sticky-zero input supports multi-precision arithmetic. When it is set, Z can only stay set if it was already set in the previous flag word, so a chain of partial results reports zero only when every partial was zero. The block also outputs the class code to be stored next. It reports an unused class code on an error output.

Top module: `ccf_flag_eval`

## Requirements
- R1: The flag word has C at bit 0, V at bit 1, Z at bit 2, N at bit 3 and X at bit 4. For class 0 (resolved), the word equals bits 4:0 of the stored result.
- R2: For computed classes (codes 1 to 8), Z is set exactly when the result is zero at the class width. N is set exactly when the result is nonzero and its top bit at that width is 1. X is 0. Class 1 (logic) sets only N and Z.
- R3: Class 2 (add): C is set when the result is unsigned-less-than the operand. V is set when adding the operand to (result − operand) overflows as a signed 32-bit operation.
- R4: Class 3 (subtract): m is result + operand. C is set when m is unsigned-less-than the operand. V is set when the signed subtraction m − operand overflows.
- R5: Classes 4 (byte compare) and 5 (word compare) apply the R4 rule to the low 8 or 16 bits only, including N and Z. Bits above that width have no effect.
- R6: Class 6 (add with extend): C is set when the result is unsigned-less-than-or-equal to the operand. V is set when adding the operand and 1 to (result − operand − 1) overflows as a signed operation.
- R7: Class 7 (subtract with extend): m is result + operand + 1. C is set when m is unsigned-less-than-or-equal to the operand. V is set when the signed operation m − operand − 1 overflows.
- R8: Class 8 (shift): C is set when the stored operand is nonzero. V is 0.
- R9: When keep_z is 1, the output Z is the computed Z ANDed with prev_z. All other flag bits are unchanged.
- R10: Class codes 9 to 15 set bad_class to 1 and force the flag word to zero. Valid codes leave bad_class at 0.
- R11: next_class is 0 for every valid class code. For an invalid code it echoes the input code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_in | input | 4 | Stored operation class code |
| res_in | input | 32 | Stored result value |
| opd_in | input | 32 | Stored second operand (shift: shifted-out bit) |
| keep_z | input | 1 | Enable sticky-zero combining |
| prev_z | input | 1 | Z bit of the previous flag word |
| flags_out | output | 5 | Resolved flag word {X,N,Z,V,C} |
| next_class | output | 4 | Class code to store after resolution |
| bad_class | output | 1 | Class code is not defined |

## Verification
A fixed table applies each class to hand-worked operands. The cases include results that wrap through zero, sign-boundary crossings that separate V from C, and compare operands whose upper bits would change the answer if they were not ignored. Every class is then driven with every pair drawn from 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These pairs tell the strict carry tests of plain add and subtract apart from the non-strict tests of the extend variants, and they expose any off-by-one in the recovered minuend. Random operands, with keep_z and prev_z toggled, are checked against a bench model that uses 64-bit signed arithmetic instead of sign-bit formulas. Directed cases cover sticky zero and the unused class codes.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    localparam int FLAG_W  = 5;
    localparam int CLASS_W = 4;

    typedef enum logic [CLASS_W-1:0] {
        CLS_RESOLVED = 4'd0,
        CLS_LOGIC    = 4'd1,
        CLS_ADD      = 4'd2,
        CLS_SUB      = 4'd3,
        CLS_CMP8     = 4'd4,
        CLS_CMP16    = 4'd5,
        CLS_ADDEXT   = 4'd6,
        CLS_SUBEXT   = 4'd7,
        CLS_SHIFT    = 4'd8
    } cc_class_e;

    localparam logic [CLASS_W-1:0] LAST_CLASS = 4'd8;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // lane 0: byte compare, lane 1: word compare, lane 2: full width
    localparam int N_LANES = 3;

    function automatic int lane_width(input int idx, input int full_w);
        if (idx == 0)      return 8;
        else if (idx == 1) return 16;
        else               return full_w;
    endfunction

endpackage

// File: rtl/ccf_nz.sv
module ccf_nz #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    output logic         neg,
    output logic         zero
);
    always_comb begin
        zero = (val == '0);
        neg  = val[W-1];
    end
endmodule

// File: rtl/ccf_sub_lane.sv
module ccf_sub_lane #(
    parameter int W = 32
) (
    input  logic [W-1:0] dest,
    input  logic [W-1:0] src,
    output logic         neg,
    output logic         zero,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] minuend;
    logic [W-1:0] ov_term;

    ccf_nz #(.W(W)) nz_i (.val(dest), .neg(neg), .zero(zero));

    always_comb begin
        minuend = dest + src;
        carry   = (minuend < src);
        ov_term = (minuend ^ dest) & (minuend ^ src);
        ovf     = ov_term[W-1];
    end
endmodule

// File: rtl/ccf_ext_unit.sv
module ccf_ext_unit
    import ccf_pkg::*;
#(
    parameter int W = 32
) (
    input  cc_class_e    cls,
    input  logic [W-1:0] dest,
    input  logic [W-1:0] src,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] back_add;
    logic [W-1:0] back_addx;
    logic [W-1:0] fwd_subx;
    logic [W-1:0] ov_add;
    logic [W-1:0] ov_addx;
    logic [W-1:0] ov_subx;

    always_comb begin
        back_add  = dest - src;
        back_addx = dest - src - 1'b1;
        fwd_subx  = dest + src + 1'b1;
        ov_add    = (src ^ dest) & ~(back_add ^ src);
        ov_addx   = (src ^ dest) & ~(back_addx ^ src);
        ov_subx   = (fwd_subx ^ dest) & (fwd_subx ^ src);
        carry = 1'b0;
        ovf   = 1'b0;
        case (cls)
            CLS_ADD: begin
                carry = (dest < src);
                ovf   = ov_add[W-1];
            end
            CLS_ADDEXT: begin
                carry = (dest <= src);
                ovf   = ov_addx[W-1];
            end
            CLS_SUBEXT: begin
                carry = (fwd_subx <= src);
                ovf   = ov_subx[W-1];
            end
            default: begin
                carry = 1'b0;
                ovf   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ccf_flag_eval.sv
module ccf_flag_eval
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CLASS_W-1:0] cls_in,
    input  logic [DATA_W-1:0]  res_in,
    input  logic [DATA_W-1:0]  opd_in,
    input  logic               keep_z,
    input  logic               prev_z,
    output logic [FLAG_W-1:0]  flags_out,
    output logic [CLASS_W-1:0] next_class,
    output logic               bad_class
);
    localparam int FULL = N_LANES - 1;

    logic [N_LANES-1:0] ln_n;
    logic [N_LANES-1:0] ln_z;
    logic [N_LANES-1:0] ln_c;
    logic [N_LANES-1:0] ln_v;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = lane_width(g, DATA_W);
        ccf_sub_lane #(.W(LW)) lane_i (
            .dest  (res_in[LW-1:0]),
            .src   (opd_in[LW-1:0]),
            .neg   (ln_n[g]),
            .zero  (ln_z[g]),
            .carry (ln_c[g]),
            .ovf   (ln_v[g])
        );
    end

    cc_class_e cls;
    logic      ext_c;
    logic      ext_v;
    ccr_t      f;

    assign cls = cc_class_e'(cls_in);

    ccf_ext_unit #(.W(DATA_W)) ext_i (
        .cls   (cls),
        .dest  (res_in),
        .src   (opd_in),
        .carry (ext_c),
        .ovf   (ext_v)
    );

    always_comb begin
        f         = '0;
        bad_class = (cls_in > LAST_CLASS);
        case (cls)
            CLS_RESOLVED: f = ccr_t'(res_in[FLAG_W-1:0]);
            CLS_LOGIC: begin
                f.z = ln_z[FULL];
                f.n = ln_n[FULL] & ~ln_z[FULL];
            end
            CLS_ADD, CLS_ADDEXT, CLS_SUBEXT: begin
                f.z = ln_z[FULL];
                f.n = ln_n[FULL] & ~ln_z[FULL];
                f.c = ext_c;
                f.v = ext_v;
            end
            CLS_SUB: begin
                f.z = ln_z[FULL];
                f.n = ln_n[FULL] & ~ln_z[FULL];
                f.c = ln_c[FULL];
                f.v = ln_v[FULL];
            end
            CLS_CMP8: begin
                f.z = ln_z[0];
                f.n = ln_n[0] & ~ln_z[0];
                f.c = ln_c[0];
                f.v = ln_v[0];
            end
            CLS_CMP16: begin
                f.z = ln_z[1];
                f.n = ln_n[1] & ~ln_z[1];
                f.c = ln_c[1];
                f.v = ln_v[1];
            end
            CLS_SHIFT: begin
                f.z = ln_z[FULL];
                f.n = ln_n[FULL] & ~ln_z[FULL];
                f.c = (opd_in != '0);
            end
            default: f = '0;
        endcase
        if (keep_z) f.z = f.z & prev_z;
        flags_out  = f;
        next_class = bad_class ? cls_in : CLS_RESOLVED;
    end
endmodule

// File: rtl/ccf_flag_eval_chk.sv
module ccf_flag_eval_chk
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic [CLASS_W-1:0] cls_in,
    input logic [DATA_W-1:0]  res_in,
    input logic [DATA_W-1:0]  opd_in,
    input logic               keep_z,
    input logic               prev_z,
    input logic [FLAG_W-1:0]  flags_out,
    input logic [CLASS_W-1:0] next_class,
    input logic               bad_class
);
    always_comb begin
        if (!keep_z && cls_in == 4'd0)
            p_passthru_r1: assert (flags_out == res_in[FLAG_W-1:0])
                else $error("pass-through mismatch");
        if (cls_in != 4'd0)
            p_nz_excl_r2: assert (!(flags_out[3] && flags_out[2]))
                else $error("N and Z both set");
        if (cls_in != 4'd0)
            p_x_clear_r2: assert (!flags_out[4])
                else $error("X set by computed class");
        if (cls_in == 4'd8)
            p_shift_c_r8: assert (flags_out[0] == (opd_in != '0) && !flags_out[1])
                else $error("shift carry mismatch");
        if (keep_z && !prev_z)
            p_sticky_r9: assert (!flags_out[2])
                else $error("sticky zero violated");
        if (bad_class)
            p_err_zero_r10: assert (flags_out == '0 && next_class == cls_in)
                else $error("invalid class not cleared");
        if (!bad_class)
            p_next_r11: assert (next_class == 4'd0)
                else $error("next class not resolved");
    end
endmodule

bind ccf_flag_eval ccf_flag_eval_chk #(.DATA_W(DATA_W)) chk_i (
    .cls_in     (cls_in),
    .res_in     (res_in),
    .opd_in     (opd_in),
    .keep_z     (keep_z),
    .prev_z     (prev_z),
    .flags_out  (flags_out),
    .next_class (next_class),
    .bad_class  (bad_class)
);

// File: tb/ccf_flag_eval_tb_top.sv
module ccf_flag_eval_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [3:0]  cls_in;
    logic [31:0] res_in;
    logic [31:0] opd_in;
    logic        keep_z;
    logic        prev_z;
    logic [4:0]  flags_out;
    logic [3:0]  next_class;
    logic        bad_class;

    int total = 0;
    int bad   = 0;

    ccf_flag_eval dut_i (
        .cls_in(cls_in), .res_in(res_in), .opd_in(opd_in),
        .keep_z(keep_z), .prev_z(prev_z),
        .flags_out(flags_out), .next_class(next_class), .bad_class(bad_class)
    );

    // {class, result, operand, expected flags}
    localparam logic [72:0] VEC [16] = '{
        {4'd0, 32'h0000001F, 32'h00000000, 5'h1F},  // R1
        {4'd0, 32'hFFFFFFE5, 32'h12345678, 5'h05},  // R1
        {4'd1, 32'h00000000, 32'hFFFFFFFF, 5'h04},  // R2
        {4'd1, 32'h80000000, 32'h00000001, 5'h08},  // R2
        {4'd2, 32'h00000000, 32'h00000001, 5'h05},  // R3
        {4'd2, 32'h80000000, 32'h00000001, 5'h0A},  // R3
        {4'd3, 32'h00000000, 32'h00000005, 5'h04},  // R4
        {4'd3, 32'hFFFFFFFF, 32'h00000001, 5'h09},  // R4
        {4'd3, 32'h7FFFFFFF, 32'h00000001, 5'h02},  // R4
        {4'd4, 32'h12345680, 32'h00000001, 5'h08},  // R5
        {4'd4, 32'hFFFFFF00, 32'h00000010, 5'h04},  // R5
        {4'd5, 32'h00007FFF, 32'hFFFF0001, 5'h02},  // R5
        {4'd6, 32'h00000005, 32'h00000005, 5'h01},  // R6
        {4'd7, 32'hFFFFFFFF, 32'h00000000, 5'h09},  // R7
        {4'd8, 32'h00000000, 32'h00000001, 5'h05},  // R8
        {4'd8, 32'h00000040, 32'h00000000, 5'h00}   // R8
    };

    localparam logic [31:0] EDGE [5] = '{
        32'h00000000, 32'h00000001, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF
    };

    function automatic logic [1:0] nz_of(input logic [31:0] r, input int w);
        logic [31:0] m;
        m = (w == 32) ? r : (r & ((32'd1 << w) - 32'd1));
        if (m == 0) return 2'b01;
        if (m[w-1]) return 2'b10;
        return 2'b00;
    endfunction

    // overflow of a + b + k as a signed w-bit operation, by wide arithmetic
    function automatic logic sadd_ovf(input logic [31:0] a, input logic [31:0] b,
                                      input longint k, input int w);
        longint sa, sb, s, lo, hi;
        sa = (w == 32) ? longint'($signed(a)) : (w == 16 ? longint'($signed(a[15:0])) : longint'($signed(a[7:0])));
        sb = (w == 32) ? longint'($signed(b)) : (w == 16 ? longint'($signed(b[15:0])) : longint'($signed(b[7:0])));
        s  = sa + sb + k;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        return (s > hi) || (s < lo);
    endfunction

    function automatic logic [4:0] model(input logic [3:0] op, input logic [31:0] d,
                                         input logic [31:0] s, input logic kz, input logic pz);
        logic [4:0]  f;
        logic [1:0]  nz;
        longint      ud, us, um;
        int          w;
        f  = 5'h00;
        ud = longint'({32'd0, d});
        us = longint'({32'd0, s});
        w  = (op == 4'd4) ? 8 : ((op == 4'd5) ? 16 : 32);
        nz = nz_of(d, w);
        f[3] = nz[1];
        f[2] = nz[0];
        case (op)
            4'd0: f = d[4:0];
            4'd1: ;
            4'd2: begin f[0] = (ud < us); f[1] = sadd_ovf(d - s, s, 0, 32); end
            4'd3, 4'd4, 4'd5: begin
                um = (ud + us) % (longint'(1) <<< w);
                f[0] = (um < (us % (longint'(1) <<< w)));
                // m - s overflows iff m + (-s) overflows; use d == m - s
                f[1] = sadd_ovf(d, s, 0, w) ^ 1'b0;
            end
            4'd6: begin f[0] = (ud <= us); f[1] = sadd_ovf(d - s - 1, s, 1, 32); end
            4'd7: begin
                um = (ud + us + 1) % (longint'(1) <<< 32);
                f[0] = (um <= us);
                f[1] = sadd_ovf(d, s, 1, 32);
            end
            4'd8: f[0] = (s != 0);
            default: f = 5'h00;
        endcase
        if (kz) f[2] = f[2] & pz;
        return f;
    endfunction

    task automatic apply(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                         input logic kz, input logic pz);
        @(negedge clk);
        cls_in = op; res_in = d; opd_in = s; keep_z = kz; prev_z = pz;
        #1;
    endtask

    task automatic check(input string req, input logic [4:0] exp_f,
                         input logic exp_bad, input logic [3:0] exp_next);
        total++;
        if (flags_out !== exp_f || bad_class !== exp_bad || next_class !== exp_next) begin
            bad++;
            $display("FAIL %s: cls=%0d res=%h opd=%h flags=%h bad=%b next=%0d, expected flags=%h bad=%b next=%0d",
                     req, cls_in, res_in, opd_in, flags_out, bad_class, next_class,
                     exp_f, exp_bad, exp_next);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        cls_in = 0; res_in = 0; opd_in = 0; keep_z = 0; prev_z = 0;

        // idle state: resolved class with zero result
        apply(4'd0, 32'd0, 32'd0, 1'b0, 1'b0);
        check("R1 idle", 5'h00, 1'b0, 4'd0);

        foreach (VEC[i]) begin
            apply(VEC[i][72:69], VEC[i][68:37], VEC[i][36:5], 1'b0, 1'b0);
            check(req_of(VEC[i][72:69]), VEC[i][4:0], 1'b0, 4'd0);  // R11 too
        end

        // edge pairs across every class (R2..R8)
        for (int op = 0; op < 9; op++)
            for (int a = 0; a < 5; a++)
                for (int b = 0; b < 5; b++) begin
                    apply(4'(op), EDGE[a], EDGE[b], 1'b0, 1'b0);
                    check(req_of(4'(op)), model(4'(op), EDGE[a], EDGE[b], 1'b0, 1'b0), 1'b0, 4'd0);
                end

        // random operands with sticky zero toggled (R2..R9)
        for (int k = 0; k < 400; k++) begin
            logic [3:0]  op;
            logic [31:0] d, s;
            logic        kz, pz;
            op = 4'($urandom_range(0, 8));
            d  = $urandom;
            s  = $urandom;
            if (k % 7 == 0) d = 32'd0;
            if (k % 11 == 0) s = 32'd0;
            kz = 1'($urandom);
            pz = 1'($urandom);
            apply(op, d, s, kz, pz);
            check((kz ? "R9" : req_of(op)), model(op, d, s, kz, pz), 1'b0, 4'd0);
        end

        // R9 sticky zero, add with extend, zero result
        apply(4'd6, 32'd0, 32'd1, 1'b1, 1'b0);
        check("R9 sticky cleared", 5'h01, 1'b0, 4'd0);
        apply(4'd6, 32'd0, 32'd1, 1'b1, 1'b1);
        check("R9 sticky kept", 5'h05, 1'b0, 4'd0);
        apply(4'd7, 32'd5, 32'd3, 1'b1, 1'b1);
        check("R9 nonzero clears", 5'h00, 1'b0, 4'd0);
        apply(4'd6, 32'd0, 32'd1, 1'b0, 1'b0);
        check("R9 disabled", 5'h05, 1'b0, 4'd0);

        // R10 / R11 invalid classes
        for (int op = 9; op < 16; op++) begin
            apply(4'(op), 32'h0, 32'hFFFFFFFF, 1'b0, 1'b1);
            check("R10", 5'h00, 1'b1, 4'(op));
        end
        apply(4'd8, 32'h1, 32'h0, 1'b0, 1'b0);
        check("R11 valid after invalid", 5'h00, 1'b0, 4'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule